// File: doc/BRIEF.md
# Network Adapter Host-Interface Glue Controller

This block joins a 32-byte host I/O decode to the register set of a network controller. It holds two control registers and a cabling register. Eight bytes at offset 0x08 form a paged window. One control bit maps that window either onto the controller's registers or onto a small identification ROM. A second bit picks one of the two ROM pages. The controller sees only two low address bits from the host. A glue bit supplies its third, upper register-select line.

The block also drives the controller's active-low reset and the ring speed select. It keeps a cable-type output and latches the controller's interrupt toward the level-sensitive host interrupt line. Software clears that latch by turning the interrupt enable off and back on. A new rising edge from the controller after that sets the latch again. The controller here is a small register stub. The ROM bytes come from parameters.

Top module: `nic_host_glue`

## Requirements
- R1: After a synchronous reset all control bits are 0, so `host_irq`, `ctl_reset_n`, `ctl_rsel_hi`, `speed16` and `cable_utp` are 0 and the ROM is mapped. Read data is returned in the cycle after the clock edge that samples `io_rd`.
- R2: With control 0 bit 2 clear and bit 3 clear, window offsets 0x08..0x0D read the manufacturer ID, the card type, the revision and configuration copies 0, 1, 2, in that order.
- R3: With control 0 bit 2 clear and bit 3 set, offset 0x08 reads 0 and offsets 0x09..0x0E read the six address bytes, most significant first.
- R4: With control 0 bit 2 set, the window reads and writes controller registers. Window writes made while the ROM is mapped leave the controller registers unchanged.
- R5: Control 1 bit 2 drives `ctl_rsel_hi` and forms the top bit of the 3-bit controller register index {bit2, addr[1:0]}.
- R6: Only address bits [1:0] select within the window for controller access, so offsets 0x0C..0x0F alias 0x08..0x0B.
- R7: When control 1 bit 1 (interrupt enable) is set, a rising edge on `ctl_irq` sets the interrupt latch. The latch drives `host_irq` and reads back as control 0 bit 7.
- R8: While the interrupt enable is clear, the latch is held clear. Re-enabling it with `ctl_irq` still high does not set the latch. A later rising edge does.
- R9: A rising edge on `ctl_irq` while the enable is clear leaves `host_irq` at 0.
- R10: Control 1 bit 0 drives `ctl_reset_n`. While it is 0 the controller registers are held at 0 and ignore writes.
- R11: Control 1 bit 3 drives `speed16`: 1 selects 16 Mb/s and 0 selects 4 Mb/s.
- R12: A write to offset 0x07 stores the byte. Bit 0 drives `cable_utp`: 1 selects UTP and 0 selects STP.
- R13: The control registers at 0x00 and 0x01 and the cabling register read back their last written values. Control 0 bit 7 is read-only. Offsets outside 0x00, 0x01, 0x07 and the window read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | AW | Byte offset within the 32-byte decode |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | DW | Write data |
| io_rdata | output | DW | Registered read data |
| ctl_irq | input | 1 | Interrupt request from the controller |
| host_irq | output | 1 | Latched level interrupt to the host |
| ctl_reset_n | output | 1 | Active-low controller reset |
| ctl_rsel_hi | output | 1 | Upper controller register-select line |
| speed16 | output | 1 | Ring speed select, 1 = 16 Mb/s |
| cable_utp | output | 1 | Cable select, 1 = UTP, 0 = STP |

## Verification
The properties assume that `io_wr` and `io_rd` are never both set in one cycle. They also assume that `ctl_irq` changes only between clock edges, so that one rising edge is seen as exactly one edge. The stimulus meets both assumptions: it drives every input just after a falling clock edge and performs each access as a single-strobe task. Interrupt sequences keep `ctl_irq` high across enable toggles, so the rule that a held level cannot re-arm the latch is exercised directly.

// File: rtl/nhg_pkg.sv
package nhg_pkg;
  // host byte offsets whose decode the glue owns
  localparam int OFS_CTRL0 = 0;
  localparam int OFS_CTRL1 = 1;
  localparam int OFS_CABLE = 7;

  // control 0 fields
  localparam int C0_MAP  = 2;  // 1: controller registers in window
  localparam int C0_PAGE = 3;  // ROM page select
  localparam int C0_STAT = 7;  // read-only latched interrupt

  // control 1 fields
  localparam int C1_RUN   = 0;  // controller out of reset
  localparam int C1_INTEN = 1;  // pass interrupt to host
  localparam int C1_RSHI  = 2;  // upper register-select line
  localparam int C1_SPD   = 3;  // 16 Mb/s when set

  localparam int WIN_BYTES = 8;
  localparam int ROM_BYTES = 2 * WIN_BYTES;
endpackage

// File: rtl/nhg_ctrl_regs.sv
module nhg_ctrl_regs
  import nhg_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          ctl_irq,
  output logic [DW-1:0] ctrl0_q,
  output logic [DW-1:0] ctrl1_q,
  output logic [DW-1:0] cable_q,
  output logic          irq_latch
);
  logic irq_prev;
  logic hit0, hit1, hitc;

  assign hit0 = io_wr && (io_addr == AW'(OFS_CTRL0));
  assign hit1 = io_wr && (io_addr == AW'(OFS_CTRL1));
  assign hitc = io_wr && (io_addr == AW'(OFS_CABLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      cable_q <= '0;
    end else begin
      if (hit0) begin
        ctrl0_q          <= io_wdata;
        ctrl0_q[C0_STAT] <= 1'b0;
      end
      if (hit1) ctrl1_q <= io_wdata;
      if (hitc) cable_q <= io_wdata;
    end
  end

  // edge-armed latch; a cleared enable holds it clear
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev  <= 1'b0;
      irq_latch <= 1'b0;
    end else begin
      irq_prev <= ctl_irq;
      if (!ctrl1_q[C1_INTEN])
        irq_latch <= 1'b0;
      else if (ctl_irq && !irq_prev)
        irq_latch <= 1'b1;
    end
  end
endmodule

// File: rtl/nhg_id_rom.sv
module nhg_id_rom
  import nhg_pkg::*;
#(
  parameter logic [7:0]  MFG_ID    = 8'h4D,
  parameter logic [7:0]  CARD_TYPE = 8'h08,
  parameter logic [7:0]  CARD_REV  = 8'h03,
  parameter logic [7:0]  CFG0      = 8'hC5,
  parameter logic [7:0]  CFG1      = 8'h44,
  parameter logic [7:0]  CFG2      = 8'h30,
  parameter logic [47:0] BIA       = 48'h0000F6A1B2C3
) (
  input  logic       page,
  input  logic [2:0] idx,
  output logic [7:0] data_o
);
  localparam int ADDR_BYTES = 6;
  localparam int P1_BASE    = WIN_BYTES + 1;

  logic [7:0] rom [ROM_BYTES];

  assign rom[0] = MFG_ID;
  assign rom[1] = CARD_TYPE;
  assign rom[2] = CARD_REV;
  assign rom[3] = CFG0;
  assign rom[4] = CFG1;
  assign rom[5] = CFG2;
  assign rom[6] = 8'h00;
  assign rom[7] = 8'h00;
  assign rom[WIN_BYTES] = 8'h00;
  assign rom[ROM_BYTES-1] = 8'h00;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign rom[P1_BASE+g] = BIA[8*(ADDR_BYTES-1-g) +: 8];
  end

  assign data_o = rom[{page, idx}];
endmodule

// File: rtl/nhg_ctl_stub.sv
module nhg_ctl_stub #(
  parameter int DW   = 8,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            wr_en,
  input  logic [SELW-1:0] sel,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  localparam int NREG = 1 << SELW;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[sel] <= wdata;
    end
  end

  assign rdata = regs[sel];
endmodule

// File: rtl/nic_host_glue.sv
module nic_host_glue
  import nhg_pkg::*;
#(
  parameter int          AW        = 5,
  parameter int          DW        = 8,
  parameter int          WIN_BASE  = 8,
  parameter int          SEL_LOW   = 2,
  parameter logic [7:0]  MFG_ID    = 8'h4D,
  parameter logic [7:0]  CARD_TYPE = 8'h08,
  parameter logic [7:0]  CARD_REV  = 8'h03,
  parameter logic [7:0]  CFG0      = 8'hC5,
  parameter logic [7:0]  CFG1      = 8'h44,
  parameter logic [7:0]  CFG2      = 8'h30,
  parameter logic [47:0] BIA       = 48'h0000F6A1B2C3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic          ctl_irq,
  output logic          host_irq,
  output logic          ctl_reset_n,
  output logic          ctl_rsel_hi,
  output logic          speed16,
  output logic          cable_utp
);
  localparam int WIN_LSB = $clog2(WIN_BYTES);
  localparam int WIN_TAG = WIN_BASE / WIN_BYTES;
  localparam int SELW    = SEL_LOW + 1;

  logic [DW-1:0]   ctrl0_q, ctrl1_q, cable_q, stub_rd, rd_mux;
  logic            irq_latch, win_hit, stub_wr;
  logic [SELW-1:0] ctl_sel;
  logic [7:0]      rom_byte;

  nhg_ctrl_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .ctl_irq(ctl_irq), .ctrl0_q(ctrl0_q),
    .ctrl1_q(ctrl1_q), .cable_q(cable_q), .irq_latch(irq_latch)
  );

  assign win_hit = (io_addr[AW-1:WIN_LSB] == (AW-WIN_LSB)'(WIN_TAG));
  assign ctl_sel = {ctrl1_q[C1_RSHI], io_addr[SEL_LOW-1:0]};
  assign stub_wr = io_wr && win_hit && ctrl0_q[C0_MAP];

  nhg_ctl_stub #(.DW(DW), .SELW(SELW)) u_stub (
    .clk(clk), .rst(rst), .run(ctrl1_q[C1_RUN]), .wr_en(stub_wr),
    .sel(ctl_sel), .wdata(io_wdata), .rdata(stub_rd)
  );

  nhg_id_rom #(
    .MFG_ID(MFG_ID), .CARD_TYPE(CARD_TYPE), .CARD_REV(CARD_REV),
    .CFG0(CFG0), .CFG1(CFG1), .CFG2(CFG2), .BIA(BIA)
  ) u_rom (
    .page(ctrl0_q[C0_PAGE]), .idx(io_addr[WIN_LSB-1:0]), .data_o(rom_byte)
  );

  always_comb begin
    rd_mux = '0;
    if (win_hit) begin
      rd_mux = ctrl0_q[C0_MAP] ? stub_rd : DW'(rom_byte);
    end else if (io_addr == AW'(OFS_CTRL0)) begin
      rd_mux          = ctrl0_q;
      rd_mux[C0_STAT] = irq_latch;
    end else if (io_addr == AW'(OFS_CTRL1)) begin
      rd_mux = ctrl1_q;
    end else if (io_addr == AW'(OFS_CABLE)) begin
      rd_mux = cable_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_mux;
  end

  assign host_irq    = irq_latch;
  assign ctl_reset_n = ctrl1_q[C1_RUN];
  assign ctl_rsel_hi = ctrl1_q[C1_RSHI];
  assign speed16     = ctrl1_q[C1_SPD];
  assign cable_utp   = cable_q[0];
endmodule

// File: rtl/nic_host_glue_chk.sv
module nic_host_glue_chk #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] io_addr,
  input logic          io_wr,
  input logic [DW-1:0] io_wdata,
  input logic          ctl_irq,
  input logic          host_irq,
  input logic          ctl_reset_n,
  input logic          ctl_rsel_hi,
  input logic          speed16,
  input logic          cable_utp
);
  logic wr_c1, wr_cab;
  assign wr_c1  = io_wr && (io_addr == AW'(1));
  assign wr_cab = io_wr && (io_addr == AW'(7));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!host_irq && !ctl_reset_n && !ctl_rsel_hi && !speed16 && !cable_utp));

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_irq) |-> $past(ctl_irq));

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_c1 && !io_wdata[1]) |=> ##1 !host_irq);

  // R10
  hold_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_c1 && !io_wdata[0]) |=> !ctl_reset_n);

  // R5
  rsel_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_c1 |=> (ctl_rsel_hi == $past(io_wdata[2])));

  // R11
  speed_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_c1 |=> (speed16 == $past(io_wdata[3])));

  // R12
  cable_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cab |=> (cable_utp == $past(io_wdata[0])));
endmodule

bind nic_host_glue nic_host_glue_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
  .io_wdata(io_wdata), .ctl_irq(ctl_irq), .host_irq(host_irq),
  .ctl_reset_n(ctl_reset_n), .ctl_rsel_hi(ctl_rsel_hi),
  .speed16(speed16), .cable_utp(cable_utp)
);

// File: tb/nic_host_glue_test.sv
`timescale 1ns/1ps
module nic_host_glue_test;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam logic [7:0] E_ROM0 [6] = '{8'h4D, 8'h08, 8'h03, 8'hC5, 8'h44, 8'h30};
  localparam logic [47:0] E_BIA = 48'h0000F6A1B2C3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0, ctl_irq = 1'b0;
  logic [DW-1:0] io_wdata = '0;
  logic [DW-1:0] io_rdata;
  logic host_irq, ctl_reset_n, ctl_rsel_hi, speed16, cable_utp;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nic_host_glue uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ctl_irq(ctl_irq),
    .host_irq(host_irq), .ctl_reset_n(ctl_reset_n), .ctl_rsel_hi(ctl_rsel_hi),
    .speed16(speed16), .cable_utp(cable_utp)
  );

  // ---------------- behavioural reference model ----------------
  int m_c0, m_c1, m_cab, m_rdata;
  bit m_latch, m_prev;
  int m_regs [8];

  function automatic int model_read(int a);
    if (a >= 8 && a < 16) begin
      if (m_c0[2]) return m_regs[(m_c1[2] ? 4 : 0) + (a % 4)];
      if (!m_c0[3]) return (a - 8 < 6) ? int'(E_ROM0[a-8]) : 0;
      if (a - 8 >= 1 && a - 8 <= 6) return int'(E_BIA[8*(6-(a-8)) +: 8]);
      return 0;
    end
    if (a == 0) return (m_c0 & 8'h7F) | (m_latch ? 8'h80 : 0);
    if (a == 1) return m_c1;
    if (a == 7) return m_cab;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_c0 = 0; m_c1 = 0; m_cab = 0; m_rdata = 0; m_latch = 0; m_prev = 0;
      foreach (m_regs[i]) m_regs[i] = 0;
    end else begin
      if (io_rd) m_rdata = model_read(int'(io_addr));
      if (!m_c1[0]) foreach (m_regs[i]) m_regs[i] = 0;
      else if (io_wr && io_addr >= 8 && io_addr < 16 && m_c0[2])
        m_regs[(m_c1[2] ? 4 : 0) + (int'(io_addr) % 4)] = int'(io_wdata);
      if (!m_c1[1]) m_latch = 0;
      else if (ctl_irq && !m_prev) m_latch = 1;
      m_prev = ctl_irq;
      if (io_wr && io_addr == 0) m_c0 = int'(io_wdata) & 8'h7F;
      if (io_wr && io_addr == 1) m_c1 = int'(io_wdata);
      if (io_wr && io_addr == 7) m_cab = int'(io_wdata);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 model host_irq", int'(host_irq), int'(m_latch));
      chk("R10 model ctl_reset_n", int'(ctl_reset_n), int'(m_c1[0]));
      chk("R5 model ctl_rsel_hi", int'(ctl_rsel_hi), int'(m_c1[2]));
      chk("R11 model speed16", int'(speed16), int'(m_c1[3]));
      chk("R12 model cable_utp", int'(cable_utp), int'(m_cab[0]));
      chk("R13 model io_rdata", int'(io_rdata), m_rdata);
    end
  end

  // ---------------- access tasks ----------------
  task automatic wr(int a, int d);
    @(negedge clk);
    io_addr = AW'(a); io_wdata = DW'(d); io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    io_addr = AW'(a); io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = int'(io_rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    int d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 host_irq", int'(host_irq), 0);
    chk("R1 ctl_reset_n", int'(ctl_reset_n), 0);
    chk("R1 ctl_rsel_hi", int'(ctl_rsel_hi), 0);
    chk("R1 speed16", int'(speed16), 0);
    chk("R1 cable_utp", int'(cable_utp), 0);
    rd(0, d); chk("R1 ctrl0 after reset", d, 0);
    // R2 ROM page 0
    for (int i = 0; i < 6; i++) begin
      rd(8 + i, d); chk("R2 rom page0", d, int'(E_ROM0[i]));
    end
    // R3 ROM page 1
    wr(0, 8'h08);
    rd(8, d); chk("R3 page1 byte0", d, 0);
    for (int i = 0; i < 6; i++) begin
      rd(9 + i, d); chk("R3 address byte", d, int'(E_BIA[8*(5-i) +: 8]));
    end
    // R4 writes while ROM mapped are ignored
    wr(1, 8'h01);
    wr(0, 8'h00);
    wr(9, 8'h55);
    wr(0, 8'h04);
    rd(9, d); chk("R4 ignored write while ROM mapped", d, 0);
    wr(9, 8'hA5);
    rd(9, d); chk("R4 controller register write/read", d, 8'hA5);
    // R6 aliasing of address bit 2
    rd(13, d); chk("R6 alias 0x0D", d, 8'hA5);
    // R5 upper select bank
    wr(1, 8'h05);
    chk("R5 ctl_rsel_hi set", int'(ctl_rsel_hi), 1);
    rd(9, d); chk("R5 upper bank empty", d, 0);
    wr(10, 8'h3C);
    rd(10, d); chk("R5 upper bank reg", d, 8'h3C);
    wr(1, 8'h01);
    rd(10, d); chk("R5 lower bank reg2", d, 0);
    rd(9, d); chk("R5 lower bank reg1", d, 8'hA5);
    // R13 readback and read-only status bit
    rd(1, d); chk("R13 ctrl1 readback", d, 8'h01);
    wr(0, 8'hFC);
    rd(0, d); chk("R13 ctrl0 bit7 read-only", d, 8'h7C);
    rd(16, d); chk("R13 unused 0x10", d, 0);
    rd(31, d); chk("R13 unused 0x1F", d, 0);
    wr(0, 8'h04);
    // R7 latch set by rising edge
    wr(1, 8'h03);
    ctl_irq = 1'b1;
    idle(1);
    chk("R7 host_irq set", int'(host_irq), 1);
    rd(0, d); chk("R7 status bit", d, 8'h84);
    // R8 clear by toggling, held level does not re-arm
    wr(1, 8'h01);
    idle(1);
    chk("R8 cleared by enable low", int'(host_irq), 0);
    wr(1, 8'h03);
    idle(2);
    chk("R8 held level no re-set", int'(host_irq), 0);
    ctl_irq = 1'b0; idle(1);
    ctl_irq = 1'b1; idle(1);
    chk("R8 new edge sets", int'(host_irq), 1);
    // R9 edge while disabled is ignored
    wr(1, 8'h01);
    ctl_irq = 1'b0; idle(1);
    ctl_irq = 1'b1; idle(2);
    chk("R9 gated host_irq", int'(host_irq), 0);
    rd(0, d); chk("R9 gated status", d, 8'h04);
    ctl_irq = 1'b0;
    // R11 speed
    wr(1, 8'h09);
    chk("R11 16 Mb/s", int'(speed16), 1);
    wr(1, 8'h01);
    chk("R11 4 Mb/s", int'(speed16), 0);
    // R12 cabling
    wr(7, 8'h01);
    chk("R12 UTP", int'(cable_utp), 1);
    rd(7, d); chk("R12 readback", d, 8'h01);
    wr(7, 8'hFE);
    chk("R12 STP", int'(cable_utp), 0);
    // R10 controller reset
    wr(1, 8'h00);
    chk("R10 reset asserted", int'(ctl_reset_n), 0);
    wr(8, 8'h77);
    wr(1, 8'h01);
    chk("R10 reset released", int'(ctl_reset_n), 1);
    rd(9, d); chk("R10 registers cleared", d, 0);
    rd(8, d); chk("R10 write in reset ignored", d, 0);
    idle(3);
    summary();
    $finish;
  end
endmodule